// File: doc/BRIEF.md
# Timer Channel Trigger and Clock Gating

This block is one channel of a general-purpose timer. It counts the active edges of a selected counter clock, which reaches it as a one-cycle tick in the master clock domain. A set/reset latch gates the counter and reports its state as a status bit. One command sets the latch and another clears it.

Four trigger sources can restart the channel. These are a software command, a synchronization pulse shared by all channels, a match between the counter and a compare value, and an optional external edge. The sources are merged into one pending request. That request does not act at once: it is applied at the next tick, where it clears the counter and sets the gating latch. The counter can therefore still read a nonzero value in the cycles between a trigger and the next tick.

The external trigger line is chosen according to the operating mode. In capture mode both pins are inputs, and either one can be the source. In waveform mode the source is pin B or one of three auxiliary lines, and the block reports which pins are outputs. All external lines pass through a synchronizer before their edges are detected. The block has no data stream: every port is a plain control or status signal that is sampled on each master clock edge, so there is no back-pressure.

Top module: `tmr_chan_trig`

## Requirements
- R1: After reset `cnt_val` is 0 and `clk_sta` is 0.
- R2: `cmd_clk_en` sets `clk_sta` at the next edge and `cmd_clk_dis` clears it; when both are high in one cycle, `clk_sta` becomes 0. A disable also wins over a trigger applied in the same cycle.
- R3: While `clk_sta` is 1, each cycle with `cnt_tick` high increments `cnt_val` by one, and 65535 wraps to 0. With no tick, or with `clk_sta` at 0, `cnt_val` holds.
- R4: A `cmd_sw_trig` pulse is remembered until the next cycle with `cnt_tick` high (including the same cycle). At that edge `cnt_val` becomes 0 and `clk_sta` becomes 1. Before that edge `cnt_val` holds.
- R5: A `sync_in` pulse has exactly the effect of `cmd_sw_trig`.
- R6: When `rc_trig_en` is 1 and `cnt_val` equals `rc_val` in a tick cycle, `cnt_val` becomes 0 at that edge, so the count runs 0 to `rc_val`. When `rc_trig_en` is 0 a match has no effect.
- R7: The external source depends on the mode. In capture mode (`mode_wave`=0), `etrig_sel[0]`=0 selects `pin_a_in` and 1 selects `pin_b_in`. In waveform mode, `etrig_sel` 0 selects `pin_b_in` and 1, 2 and 3 select `xc_in[0]`, `xc_in[1]` and `xc_in[2]`. Lines that are not selected, and every line while `etrig_en` is 0, have no effect on the counter.
- R8: `etrig_edge` encoding: 2'b00 selects the rising edge, 2'b01 the falling edge, and 2'b1x both edges. The detected edge then acts as a pending trigger, as in R4. A level change that holds for at least two master clock cycles is seen within three edges.
- R9: `pin_a_out_en` equals `mode_wave`. `pin_b_out_en` is 1 only in waveform mode with `etrig_sel` not 0, so pin B is an output unless it is the selected trigger source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| mode_wave | input | 1 | 0 capture mode, 1 waveform mode |
| etrig_en | input | 1 | External trigger enable |
| etrig_sel | input | 2 | External source select (R7) |
| etrig_edge | input | 2 | External edge select (R8) |
| rc_trig_en | input | 1 | Compare-match trigger enable |
| rc_val | input | 16 | Compare value |
| cmd_clk_en | input | 1 | Clock enable command pulse |
| cmd_clk_dis | input | 1 | Clock disable command pulse |
| cmd_sw_trig | input | 1 | Software trigger command pulse |
| sync_in | input | 1 | Block-wide synchronization pulse |
| cnt_tick | input | 1 | Active edge of the selected counter clock |
| pin_a_in | input | 1 | Pin A input level (asynchronous) |
| pin_b_in | input | 1 | Pin B input level (asynchronous) |
| xc_in | input | 3 | Auxiliary external lines (asynchronous) |
| cnt_val | output | 16 | Counter value |
| clk_sta | output | 1 | Clock gating latch state |
| pin_a_out_en | output | 1 | Pin A drives as output |
| pin_b_out_en | output | 1 | Pin B drives as output |

## Verification
The assertions check on every cycle that a disable clears the gating latch, and that an enable without a disable sets it. They also check that the counter holds without a tick, steps by exactly one on an ungated tick, and reads zero after any applied trigger or compare match. The bench is needed for the behaviour that spans many cycles. That covers a trigger waiting across tickless cycles, the mode-dependent choice of external line through the synchronizer, falling-edge and both-edge detection, the wrap at 65535, and the fact that lines which are not selected or not enabled are ignored.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CNT_W_DEF    = 16;
  localparam int SYNC_DEPTH   = 2;
  // external line index: 0 pin A, 1 pin B, 2..4 auxiliary lines
  localparam int EXT_LINES    = 5;
  localparam int LINE_A       = 0;
  localparam int LINE_B       = 1;
  localparam int LINE_XC0     = 2;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTHX = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int LAST = STAGES - 1;

  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[LAST];
    end
  end

  assign rise = stg[LAST] & ~prev;
  assign fall = ~stg[LAST] & prev;
endmodule

// File: rtl/tcc_trig_merge.sv
module tcc_trig_merge
  import tcc_pkg::*;
#(
  parameter int N = EXT_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wave,
  input  logic         etrig_en,
  input  logic [1:0]   etrig_sel,
  input  logic [1:0]   etrig_edge,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic         sw_trig,
  input  logic         sync_trig,
  input  logic         rc_hit,
  input  logic         cnt_tick,
  output logic         trig_apply
);
  logic [N-1:0] line_evt;
  logic [2:0]   src_idx;
  logic         ext_evt;
  logic         trig_now;
  logic         pend_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_comb begin
      unique case (edge_sel_e'(etrig_edge))
        EDGE_RISE: line_evt[g] = rise[g];
        EDGE_FALL: line_evt[g] = fall[g];
        default:   line_evt[g] = rise[g] | fall[g];
      endcase
    end
  end

  always_comb begin
    if (!mode_wave)
      src_idx = etrig_sel[0] ? 3'(LINE_B) : 3'(LINE_A);
    else if (etrig_sel == 2'd0)
      src_idx = 3'(LINE_B);
    else
      src_idx = 3'(LINE_XC0) + 3'(etrig_sel) - 3'd1;
  end

  assign ext_evt    = etrig_en & line_evt[src_idx];
  assign trig_now   = sw_trig | sync_trig | rc_hit | ext_evt;
  assign trig_apply = cnt_tick & (pend_q | trig_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (cnt_tick) pend_q <= 1'b0;
    else if (trig_now) pend_q <= 1'b1;
  end
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             clk_en_cmd,
  input  logic             clk_dis_cmd,
  input  logic             trig_apply,
  input  logic             rc_trig_en,
  input  logic [CNT_W-1:0] rc_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sta_q,
  output logic             rc_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sta_q <= 1'b0;
    else if (clk_dis_cmd)                sta_q <= 1'b0;
    else if (clk_en_cmd || trig_apply)   sta_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (trig_apply)          cnt_q <= '0;
    else if (cnt_tick && sta_q)   cnt_q <= cnt_q + 1'b1;
  end

  assign rc_hit = rc_trig_en && (cnt_q == rc_val);
endmodule

// File: rtl/tmr_chan_trig.sv
module tmr_chan_trig
  import tcc_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wave,
  input  logic             etrig_en,
  input  logic [1:0]       etrig_sel,
  input  logic [1:0]       etrig_edge,
  input  logic             rc_trig_en,
  input  logic [CNT_W-1:0] rc_val,
  input  logic             cmd_clk_en,
  input  logic             cmd_clk_dis,
  input  logic             cmd_sw_trig,
  input  logic             sync_in,
  input  logic             cnt_tick,
  input  logic             pin_a_in,
  input  logic             pin_b_in,
  input  logic [2:0]       xc_in,
  output logic [CNT_W-1:0] cnt_val,
  output logic             clk_sta,
  output logic             pin_a_out_en,
  output logic             pin_b_out_en
);
  logic [EXT_LINES-1:0] ext_raw, ext_rise, ext_fall;
  logic                 trig_apply, rc_hit;

  assign ext_raw = {xc_in, pin_b_in, pin_a_in};

  tcc_edge_sync #(.N(EXT_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_raw),
    .rise(ext_rise), .fall(ext_fall)
  );

  tcc_trig_merge #(.N(EXT_LINES)) u_merge (
    .clk(clk), .rst_n(rst_n), .mode_wave(mode_wave), .etrig_en(etrig_en),
    .etrig_sel(etrig_sel), .etrig_edge(etrig_edge),
    .rise(ext_rise), .fall(ext_fall),
    .sw_trig(cmd_sw_trig), .sync_trig(sync_in), .rc_hit(rc_hit),
    .cnt_tick(cnt_tick), .trig_apply(trig_apply)
  );

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .clk_en_cmd(cmd_clk_en), .clk_dis_cmd(cmd_clk_dis),
    .trig_apply(trig_apply), .rc_trig_en(rc_trig_en), .rc_val(rc_val),
    .cnt_q(cnt_val), .sta_q(clk_sta), .rc_hit(rc_hit)
  );

  assign pin_a_out_en = mode_wave;
  assign pin_b_out_en = mode_wave && (etrig_sel != 2'd0);
endmodule

// File: rtl/tmr_chan_trig_chk.sv
module tmr_chan_trig_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_clk_en,
  input logic             cmd_clk_dis,
  input logic             cmd_sw_trig,
  input logic             cnt_tick,
  input logic             rc_trig_en,
  input logic [CNT_W-1:0] rc_val,
  input logic [CNT_W-1:0] cnt_val,
  input logic             clk_sta,
  input logic             trig_apply
);
  // R2
  dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clk_dis |=> !clk_sta);
  // R2
  en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clk_en && !cmd_clk_dis) |=> clk_sta);
  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cnt_val));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && clk_sta && !trig_apply) |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));
  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !clk_sta && !trig_apply) |=> $stable(cnt_val));
  // R4
  sw_tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sw_trig && cnt_tick) |=> cnt_val == '0);
  // R4
  apply_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_apply |=> (cnt_val == '0));
  // R6
  rc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_trig_en && cnt_tick && cnt_val == rc_val) |=> cnt_val == '0);
endmodule

bind tmr_chan_trig tmr_chan_trig_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clk_en(cmd_clk_en), .cmd_clk_dis(cmd_clk_dis),
  .cmd_sw_trig(cmd_sw_trig), .cnt_tick(cnt_tick), .rc_trig_en(rc_trig_en),
  .rc_val(rc_val), .cnt_val(cnt_val), .clk_sta(clk_sta), .trig_apply(trig_apply)
);

// File: tb/tmr_chan_trig_tb.sv
`timescale 1ns/1ps
module tmr_chan_trig_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wave = 0, etrig_en = 0, rc_trig_en = 0;
  logic [1:0]  etrig_sel = 0, etrig_edge = 0;
  logic [15:0] rc_val = 0;
  logic        cmd_clk_en = 0, cmd_clk_dis = 0, cmd_sw_trig = 0, sync_in = 0, cnt_tick = 0;
  logic        pin_a_in = 0, pin_b_in = 0;
  logic [2:0]  xc_in = 0;
  logic [15:0] cnt_val;
  logic        clk_sta, pin_a_out_en, pin_b_out_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_cnt = 0;
  logic        m_sta = 0, m_pend = 0;

  always #2 clk = ~clk;

  tmr_chan_trig u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wave(mode_wave), .etrig_en(etrig_en),
    .etrig_sel(etrig_sel), .etrig_edge(etrig_edge), .rc_trig_en(rc_trig_en),
    .rc_val(rc_val), .cmd_clk_en(cmd_clk_en), .cmd_clk_dis(cmd_clk_dis),
    .cmd_sw_trig(cmd_sw_trig), .sync_in(sync_in), .cnt_tick(cnt_tick),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .xc_in(xc_in),
    .cnt_val(cnt_val), .clk_sta(clk_sta),
    .pin_a_out_en(pin_a_out_en), .pin_b_out_en(pin_b_out_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_trig(input logic [15:0] c);
    return cmd_sw_trig | sync_in | (rc_trig_en && c == rc_val);
  endfunction

  function automatic logic [15:0] exp_cnt(input logic [15:0] c, input logic s, input logic p);
    if (cnt_tick && (p || next_trig(c))) return 16'd0;
    if (cnt_tick && s) return c + 16'd1;
    return c;
  endfunction

  function automatic logic exp_sta(input logic [15:0] c, input logic s, input logic p);
    if (cmd_clk_dis) return 1'b0;
    if (cmd_clk_en || (cnt_tick && (p || next_trig(c)))) return 1'b1;
    return s;
  endfunction

  task automatic step();
    logic [15:0] nc;
    logic ns, np;
    nc = exp_cnt(m_cnt, m_sta, m_pend);
    ns = exp_sta(m_cnt, m_sta, m_pend);
    np = cnt_tick ? 1'b0 : (m_pend | next_trig(m_cnt));
    @(posedge clk); #1;
    m_cnt = nc; m_sta = ns; m_pend = np;
  endtask

  task automatic clear_cmds();
    cmd_clk_en = 0; cmd_clk_dis = 0; cmd_sw_trig = 0; sync_in = 0; cnt_tick = 0;
  endtask

  task automatic do_reset();
    clear_cmds();
    mode_wave = 0; etrig_en = 0; etrig_sel = 0; etrig_edge = 0; rc_trig_en = 0;
    pin_a_in = 0; pin_b_in = 0; xc_in = 0;
    rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    m_cnt = 0; m_sta = 0; m_pend = 0;
  endtask

  task automatic model_check(input string req);
    check(cnt_val == m_cnt, req, cnt_val, m_cnt);
    check(clk_sta == m_sta, req, clk_sta, m_sta);
  endtask

  // enable, then count to n with ticks
  task automatic run_to(input int n);
    cmd_clk_en = 1; step(); clear_cmds();
    cmd_sw_trig = 1; cnt_tick = 1; step(); clear_cmds();
    for (int i = 0; i < n; i++) begin cnt_tick = 1; step(); end
    clear_cmds();
  endtask

  task automatic idle(input int n);
    clear_cmds();
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(cnt_val == 0, "R1", cnt_val, 0);
    check(clk_sta == 0, "R1", clk_sta, 0);

    // R2 enable then both at once
    cmd_clk_en = 1; step(); clear_cmds();
    check(clk_sta == 1, "R2", clk_sta, 1);
    cmd_clk_en = 1; cmd_clk_dis = 1; step(); clear_cmds();
    check(clk_sta == 0, "R2", clk_sta, 0);
    // R2 disable beats trigger applied same cycle
    cmd_sw_trig = 1; cnt_tick = 1; cmd_clk_dis = 1; step(); clear_cmds();
    check(clk_sta == 0, "R2", clk_sta, 0);
    check(cnt_val == 0, "R4", cnt_val, 0);

    // R3 gated: ticks with latch off do nothing
    cnt_tick = 1; step(); step(); clear_cmds();
    check(cnt_val == 0, "R3", cnt_val, 0);

    // R4 pending software trigger waits for tick
    do_reset();
    run_to(7);
    check(cnt_val == 7, "R3", cnt_val, 7);
    cmd_sw_trig = 1; step(); clear_cmds();
    idle(3);
    check(cnt_val == 7, "R4", cnt_val, 7);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R4", cnt_val, 0);

    // R4 trigger from stopped state starts clock
    cmd_clk_dis = 1; step(); clear_cmds();
    cmd_sw_trig = 1; step(); clear_cmds();
    check(clk_sta == 0, "R4", clk_sta, 0);
    cnt_tick = 1; step(); clear_cmds();
    check(clk_sta == 1, "R4", clk_sta, 1);

    // R5 sync acts like software trigger
    do_reset();
    run_to(5);
    sync_in = 1; step(); clear_cmds();
    check(cnt_val == 5, "R5", cnt_val, 5);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R5", cnt_val, 0);

    // R6 compare trigger: period rc+1
    do_reset();
    rc_val = 16'd4; rc_trig_en = 1;
    run_to(4);
    check(cnt_val == 4, "R6", cnt_val, 4);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R6", cnt_val, 0);
    rc_trig_en = 0;
    run_to(6);
    check(cnt_val == 6, "R6", cnt_val, 6);

    // R7 capture mode, pin B selected, pin A ignored
    do_reset();
    etrig_en = 1; etrig_sel = 2'd1; etrig_edge = 2'b00;
    run_to(3);
    pin_a_in = 1; idle(5);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 4, "R7", cnt_val, 4);
    pin_b_in = 1; idle(5);
    check(cnt_val == 4, "R8", cnt_val, 4);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R7", cnt_val, 0);

    // R7 disabled external trigger ignored
    do_reset();
    etrig_en = 0; etrig_sel = 2'd1;
    run_to(2);
    pin_b_in = 1; idle(5);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 3, "R7", cnt_val, 3);

    // R7 waveform mode, XC1 selected, pin B ignored
    do_reset();
    mode_wave = 1; etrig_en = 1; etrig_sel = 2'd2;
    run_to(2);
    pin_b_in = 1; xc_in = 3'b001; idle(5);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 3, "R7", cnt_val, 3);
    xc_in = 3'b011; idle(5);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R7", cnt_val, 0);
    // R9 directions
    check(pin_a_out_en == 1, "R9", pin_a_out_en, 1);
    check(pin_b_out_en == 1, "R9", pin_b_out_en, 1);
    etrig_sel = 2'd0; #1;
    check(pin_b_out_en == 0, "R9", pin_b_out_en, 0);
    mode_wave = 0; etrig_sel = 2'd1; #1;
    check(pin_a_out_en == 0, "R9", pin_a_out_en, 0);
    check(pin_b_out_en == 0, "R9", pin_b_out_en, 0);

    // R8 falling edge only
    do_reset();
    pin_b_in = 1; idle(4);
    mode_wave = 1; etrig_en = 1; etrig_sel = 2'd0; etrig_edge = 2'b01;
    run_to(2);
    pin_b_in = 0; idle(4);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R8", cnt_val, 0);
    run_to(2);
    pin_b_in = 1; idle(4);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 3, "R8", cnt_val, 3);
    // R8 both edges
    etrig_edge = 2'b10;
    pin_b_in = 0; idle(4);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R8", cnt_val, 0);

    // R3 wrap at 65535
    do_reset();
    run_to(65535);
    check(cnt_val == 16'hFFFF, "R3", cnt_val, 65535);
    cnt_tick = 1; step(); clear_cmds();
    check(cnt_val == 0, "R3", cnt_val, 0);

    // random mix, external trigger off, pins toggling
    do_reset();
    void'($urandom(32'd1234));
    rc_val = 16'd9; rc_trig_en = 1;
    for (int i = 0; i < 4000; i++) begin
      cnt_tick    = ($urandom % 3) == 0;
      cmd_clk_en  = ($urandom % 20) == 0;
      cmd_clk_dis = ($urandom % 40) == 0;
      cmd_sw_trig = ($urandom % 50) == 0;
      sync_in     = ($urandom % 60) == 0;
      pin_a_in    = 1'($urandom);
      pin_b_in    = 1'($urandom);
      xc_in       = 3'($urandom);
      if ((i % 500) == 0) begin
        rc_trig_en = 1'($urandom);
        rc_val = 16'($urandom % 24);
      end
      step();
      model_check((i % 2) == 0 ? "R6" : "R3");
    end
    clear_cmds();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule